// File: doc/BRIEF.md
# Aliased Nibble RAM Address Unit

This block holds the address pointer for a small 4-bit data memory and the memory itself. The pointer has two fields: a register field that picks one of four banks, and a digit field that picks a nibble inside that bank. Each clock cycle one operation code is applied. The code can load the pointer, copy the accumulator into the digit field, XOR the register field with an operand, or step the digit field up or down. It can also store a nibble, exchange a nibble with the accumulator, or set or clear one bit of the addressed nibble. The accumulator sits outside the block: it supplies `acc_i` and takes the old nibble from `rd_data_o`.

Only the low three bits of the digit field reach the storage, so each physical nibble answers to two digit values. The stepping exchanges raise a skip flag only when the whole 4-bit digit field wraps around. A direct exchange always targets the last nibble of the last bank and leaves the pointer as it is. Reset clears the pointer, and the stored nibbles survive it.

Top module: `nram_addr_unit`

## Requirements
- R1: While `rst_ni` is low, `ptr_o` is 0 and `skip_o` is 0. Storage contents are kept across a reset.
- R2: `op_i`=1 (load) sets `ptr_o` to {`reg_imm_i`, `dig_imm_i`}. `ptr_o[5:4]` is the register field and `ptr_o[3:0]` is the digit field.
- R3: `op_i`=2 copies `acc_i` into the digit field and leaves the register field unchanged. The digit field is read back through `ptr_o[3:0]`.
- R4: The addressed cell is register field * 8 + digit[2:0]. Digit bit 3 is ignored, so digits d and d+8 reach the same cell.
- R5: `op_i`=4 writes `acc_i` into the addressed cell. `rd_data_o` always shows the addressed cell combinationally.
- R6: `op_i`=5 (exchange) works as follows. During the op cycle, `rd_data_o` shows the old cell value. At the clock edge, `acc_i` is stored and the register field becomes register XOR `xr_i`.
- R7: `op_i`=6 exchanges like R6 and adds 1 to the digit field modulo 16. `skip_o` is 1 for exactly the following cycle when the digit was 15, and 0 otherwise.
- R8: `op_i`=7 exchanges like R6 and subtracts 1 from the digit field modulo 16. `skip_o` is 1 for the following cycle only when the digit was 0. Stepping from 8 to 7 or from 7 to 8 never raises skip.
- R9: `op_i`=3 (read) XORs the register field with `xr_i`. It leaves the digit field and the storage unchanged.
- R10: `op_i`=8 (direct) exchanges with register 3, digit 7 (the cell that register 3, digit 15 also reaches), whatever the pointer holds. The pointer is left unchanged.
- R11: `op_i`=9 sets and `op_i`=10 clears bit `bsel_i` of the addressed cell. `bit_zero_o` is 1 when bit `bsel_i` of `rd_data_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| op_i | input | 4 | Operation code (0 = no operation; codes above 10 also do nothing) |
| reg_imm_i | input | 2 | Register field immediate for load |
| dig_imm_i | input | 4 | Digit field immediate for load |
| xr_i | input | 2 | XOR operand for the register field |
| acc_i | input | 4 | Accumulator value to store or copy |
| bsel_i | input | 2 | Bit select for set, clear and zero test |
| ptr_o | output | 6 | Pointer {register, digit} |
| rd_data_o | output | 4 | Addressed cell, or the direct cell during op 8 |
| bit_zero_o | output | 1 | Selected bit of rd_data_o is zero |
| skip_o | output | 1 | Wrap skip flag for the previous step operation |

## Verification
The results arrive at different times:
- `ptr_o` and the stored cell change at the clock edge where the operation is applied, so they are sampled at the next falling edge.
- `skip_o` is registered at the same edge and lasts exactly one cycle. It is sampled then, and checked low again after the next vector.
- The old value returned by an exchange is combinational. It is sampled one time unit after the operation is driven, before the edge.
- `bit_zero_o` follows `rd_data_o` and `bsel_i` in the same cycle.

Aliasing is checked by writing through one digit value and reading back through the digit that differs only in bit 3.

// File: rtl/nram_pkg.sv
package nram_pkg;
  typedef enum logic [3:0] {
    OP_NOP     = 4'd0,
    OP_LOAD    = 4'd1,
    OP_ACC2DIG = 4'd2,
    OP_READ    = 4'd3,
    OP_WRITE   = 4'd4,
    OP_XCH     = 4'd5,
    OP_XCH_INC = 4'd6,
    OP_XCH_DEC = 4'd7,
    OP_DIRECT  = 4'd8,
    OP_BIT_SET = 4'd9,
    OP_BIT_CLR = 4'd10
  } op_e;
endpackage

// File: rtl/nram_ptr.sv
module nram_ptr
  import nram_pkg::*;
#(
  parameter int REG_W = 2,
  parameter int DIG_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  op_e              op_i,
  input  logic [REG_W-1:0] reg_imm_i,
  input  logic [DIG_W-1:0] dig_imm_i,
  input  logic [REG_W-1:0] xr_i,
  input  logic [DIG_W-1:0] acc_i,
  output logic [REG_W-1:0] reg_o,
  output logic [DIG_W-1:0] dig_o,
  output logic             skip_o
);
  localparam int MID = 2 ** (DIG_W - 1);

  logic [REG_W-1:0] reg_q;
  logic [DIG_W-1:0] dig_q;
  logic             skip_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      reg_q  <= '0;
      dig_q  <= '0;
      skip_q <= 1'b0;
    end else begin
      // skip only on full-width wrap
      skip_q <= (op_i == OP_XCH_INC && dig_q == '1) ||
                (op_i == OP_XCH_DEC && dig_q == '0);
      unique case (op_i)
        OP_LOAD: begin
          reg_q <= reg_imm_i;
          dig_q <= dig_imm_i;
        end
        OP_ACC2DIG: dig_q <= acc_i;
        OP_READ, OP_XCH: reg_q <= reg_q ^ xr_i;
        OP_XCH_INC: begin
          reg_q <= reg_q ^ xr_i;
          dig_q <= dig_q + DIG_W'(1);
        end
        OP_XCH_DEC: begin
          reg_q <= reg_q ^ xr_i;
          dig_q <= dig_q - DIG_W'(1);
        end
        default: ;
      endcase
    end
  end

  assign reg_o  = reg_q;
  assign dig_o  = dig_q;
  assign skip_o = skip_q;

  // R7
  inc_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_XCH_INC |=> dig_q == $past(dig_q) + DIG_W'(1));
  // R8
  mid_no_skip_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (op_i == OP_XCH_DEC && dig_q == DIG_W'(MID)) |=> !skip_q);
  // R7 R8
  skip_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    skip_q |-> (($past(op_i) == OP_XCH_INC && dig_q == '0) ||
                ($past(op_i) == OP_XCH_DEC && dig_q == '1)));
  // R10
  direct_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_DIRECT |=> $stable({reg_q, dig_q}));
  // R3
  a2d_reg_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_i == OP_ACC2DIG |=> $stable(reg_q));
endmodule

// File: rtl/nram_map.sv
module nram_map #(
  parameter int REG_W = 2,
  parameter int SEL_W = 3
) (
  input  logic [REG_W-1:0]       reg_i,
  input  logic [SEL_W-1:0]       dsel_i,
  input  logic                   direct_i,
  output logic [REG_W+SEL_W-1:0] addr_o
);
  // direct cell: last register, last physical digit
  localparam logic [REG_W+SEL_W-1:0] DIRECT_ADDR = '1;

  always_comb addr_o = direct_i ? DIRECT_ADDR : {reg_i, dsel_i};
endmodule

// File: rtl/nram_store.sv
module nram_store #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  localparam int DEPTH = 2 ** ADDR_W;

  logic [DATA_W-1:0] mem_q [DEPTH];

  // no reset on contents
  always_ff @(posedge clk_i) begin
    if (we_i) mem_q[addr_i] <= wdata_i;
  end

  assign rdata_o = mem_q[addr_i];

  // R5
  wr_land_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem_q[$past(addr_i)] == $past(wdata_i));
endmodule

// File: rtl/nram_addr_unit.sv
module nram_addr_unit
  import nram_pkg::*;
#(
  parameter int REG_W  = 2,
  parameter int DIG_W  = 4,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 4
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic [3:0]             op_i,
  input  logic [REG_W-1:0]       reg_imm_i,
  input  logic [DIG_W-1:0]       dig_imm_i,
  input  logic [REG_W-1:0]       xr_i,
  input  logic [DATA_W-1:0]      acc_i,
  input  logic [$clog2(DATA_W)-1:0] bsel_i,
  output logic [REG_W+DIG_W-1:0] ptr_o,
  output logic [DATA_W-1:0]      rd_data_o,
  output logic                   bit_zero_o,
  output logic                   skip_o
);
  localparam int ADDR_W = REG_W + SEL_W;

  op_e               op;
  logic [REG_W-1:0]  reg_f;
  logic [DIG_W-1:0]  dig_f;
  logic [ADDR_W-1:0] addr;
  logic              direct;
  logic              we;
  logic [DATA_W-1:0] wdata;
  logic [DATA_W-1:0] bit_mask;

  assign op     = op_e'(op_i);
  assign direct = (op == OP_DIRECT);

  nram_ptr #(.REG_W(REG_W), .DIG_W(DIG_W)) u_ptr (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .op_i      (op),
    .reg_imm_i (reg_imm_i),
    .dig_imm_i (dig_imm_i),
    .xr_i      (xr_i),
    .acc_i     (acc_i),
    .reg_o     (reg_f),
    .dig_o     (dig_f),
    .skip_o    (skip_o)
  );

  nram_map #(.REG_W(REG_W), .SEL_W(SEL_W)) u_map (
    .reg_i    (reg_f),
    .dsel_i   (dig_f[SEL_W-1:0]),
    .direct_i (direct),
    .addr_o   (addr)
  );

  always_comb begin
    bit_mask = '0;
    bit_mask[bsel_i] = 1'b1;
    we    = 1'b1;
    wdata = acc_i;
    unique case (op)
      OP_WRITE, OP_XCH, OP_XCH_INC, OP_XCH_DEC, OP_DIRECT: ;
      OP_BIT_SET: wdata = rd_data_o | bit_mask;
      OP_BIT_CLR: wdata = rd_data_o & ~bit_mask;
      default:    we = 1'b0;
    endcase
  end

  nram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .addr_i  (addr),
    .we_i    (we),
    .wdata_i (wdata),
    .rdata_o (rd_data_o)
  );

  assign ptr_o      = {reg_f, dig_f};
  assign bit_zero_o = ~rd_data_o[bsel_i];

  // R11
  bit_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_BIT_SET |=> rd_data_o[$past(bsel_i)]);
  // R11
  bit_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op == OP_BIT_CLR |=> bit_zero_o || bsel_i != $past(bsel_i));
endmodule

// File: tb/nram_addr_unit_test.sv
module nram_addr_unit_test;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [3:0] op = '0;
  logic [1:0] reg_imm = '0;
  logic [3:0] dig_imm = '0;
  logic [1:0] xr = '0;
  logic [3:0] acc = '0;
  logic [1:0] bsel = '0;
  logic [5:0] ptr;
  logic [3:0] rd;
  logic       bz;
  logic       skip;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  nram_addr_unit uut (
    .clk_i(clk), .rst_ni(rst_ni), .op_i(op), .reg_imm_i(reg_imm),
    .dig_imm_i(dig_imm), .xr_i(xr), .acc_i(acc), .bsel_i(bsel),
    .ptr_o(ptr), .rd_data_o(rd), .bit_zero_o(bz), .skip_o(skip)
  );

  // {op, reg, dig, xr, acc, exp_ptr, exp_rd, chk_rd, exp_skip}
  localparam logic [27:0] VECS [16] = '{
    {4'd1, 2'd1, 4'd5,  2'd0, 4'h0, 6'h15, 4'h0, 1'b0, 1'b0},
    {4'd4, 2'd0, 4'd0,  2'd0, 4'hA, 6'h15, 4'hA, 1'b1, 1'b0},
    {4'd1, 2'd1, 4'd13, 2'd0, 4'h0, 6'h1D, 4'hA, 1'b1, 1'b0},
    {4'd6, 2'd0, 4'd0,  2'd0, 4'h3, 6'h1E, 4'h0, 1'b0, 1'b0},
    {4'd4, 2'd0, 4'd0,  2'd0, 4'h6, 6'h1E, 4'h6, 1'b1, 1'b0},
    {4'd6, 2'd0, 4'd0,  2'd2, 4'h7, 6'h3F, 4'h0, 1'b0, 1'b0},
    {4'd4, 2'd0, 4'd0,  2'd0, 4'h9, 6'h3F, 4'h9, 1'b1, 1'b0},
    {4'd6, 2'd0, 4'd0,  2'd1, 4'h1, 6'h20, 4'h0, 1'b0, 1'b1},
    {4'd4, 2'd0, 4'd0,  2'd0, 4'h4, 6'h20, 4'h4, 1'b1, 1'b0},
    {4'd7, 2'd0, 4'd0,  2'd0, 4'h5, 6'h2F, 4'h0, 1'b0, 1'b1},
    {4'd2, 2'd0, 4'd0,  2'd0, 4'h8, 6'h28, 4'h5, 1'b1, 1'b0},
    {4'd7, 2'd0, 4'd0,  2'd0, 4'h2, 6'h27, 4'h0, 1'b0, 1'b0},
    {4'd1, 2'd1, 4'd6,  2'd0, 4'h0, 6'h16, 4'h7, 1'b1, 1'b0},
    {4'd3, 2'd0, 4'd0,  2'd1, 4'h0, 6'h06, 4'h0, 1'b0, 1'b0},
    {4'd2, 2'd0, 4'd0,  2'd0, 4'h7, 6'h07, 4'h0, 1'b0, 1'b0},
    {4'd6, 2'd0, 4'd0,  2'd0, 4'h0, 6'h08, 4'h0, 1'b0, 1'b0}
  };

  function automatic string tag_of(logic [3:0] o);
    case (o)
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R9";
      4'd4: return "R5";
      4'd6: return "R7";
      4'd7: return "R8";
      default: return "R4";
    endcase
  endfunction

  task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic drive(logic [3:0] o, logic [1:0] r, logic [3:0] d,
                       logic [1:0] x, logic [3:0] a, logic [1:0] b);
    @(negedge clk);
    op = o; reg_imm = r; dig_imm = d; xr = x; acc = a; bsel = b;
    #1;
  endtask

  task automatic settle();
    @(negedge clk);
    op = 4'd0; xr = '0;
    #1;
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    #1;
    chk("R1 reset ptr", 8'(ptr), 8'h00);
    chk("R1 reset skip", 8'(skip), 8'h0);
    @(negedge clk);
    rst_ni = 1'b1;

    for (int i = 0; i < 16; i++) begin
      logic [27:0] v;
      v = VECS[i];
      drive(v[27:24], v[23:22], v[21:18], v[17:16], v[15:12], 2'd0);
      settle();
      chk(tag_of(v[27:24]), 8'(ptr), 8'(v[11:6]));
      chk(v[0] ? "R7 R8 skip set" : "R8 skip clear", 8'(skip), 8'(v[0]));
      if (v[1]) chk(tag_of(v[27:24]), 8'(rd), 8'(v[5:2]));
    end

    // R6: exchange shows old value, stores new, XORs register
    drive(4'd1, 2'd2, 4'd0, 2'd0, 4'h0, 2'd0);
    settle();
    chk("R4 alias read", 8'(rd), 8'h2);
    drive(4'd5, 2'd0, 4'd0, 2'd3, 4'hE, 2'd0);
    chk("R6 old value", 8'(rd), 8'h2);
    settle();
    chk("R6 xor reg", 8'(ptr), 8'h10);
    drive(4'd1, 2'd2, 4'd8, 2'd0, 4'h0, 2'd0);
    settle();
    chk("R6 stored", 8'(rd), 8'hE);

    // R10: direct exchange ignores pointer
    drive(4'd8, 2'd0, 4'd0, 2'd0, 4'hC, 2'd0);
    chk("R10 direct old", 8'(rd), 8'h1);
    settle();
    chk("R10 ptr kept", 8'(ptr), 8'h28);
    chk("R10 pointed cell kept", 8'(rd), 8'hE);
    drive(4'd1, 2'd3, 4'd15, 2'd0, 4'h0, 2'd0);
    settle();
    chk("R10 direct stored", 8'(rd), 8'hC);

    // R11: bit ops and zero test
    bsel = 2'd0; #1;
    chk("R11 zero test", 8'(bz), 8'h1);
    drive(4'd9, 2'd0, 4'd0, 2'd0, 4'h0, 2'd0);
    settle();
    chk("R11 set", 8'(rd), 8'hD);
    chk("R11 zero test set", 8'(bz), 8'h0);
    drive(4'd10, 2'd0, 4'd0, 2'd0, 4'h0, 2'd3);
    settle();
    chk("R11 clear", 8'(rd), 8'h5);
    chk("R11 ptr kept", 8'(ptr), 8'h3F);

    // R1: reset clears pointer, keeps storage
    @(negedge clk);
    rst_ni = 1'b0;
    #1;
    chk("R1 ptr cleared", 8'(ptr), 8'h00);
    chk("R1 skip cleared", 8'(skip), 8'h0);
    @(negedge clk);
    rst_ni = 1'b1;
    drive(4'd1, 2'd3, 4'd7, 2'd0, 4'h0, 2'd0);
    settle();
    chk("R1 storage kept", 8'(rd), 8'h5);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule